// File: doc/BRIEF.md
# Sequential Integer Multiplier with High/Low and Word Results

This block is the multiply unit of a 64-bit integer execution pipe. A caller presents two source operands, a 3-bit operation code and a one-cycle start strobe. The unit captures everything on the accepted start and reports busy while it works. It ends the operation with a one-cycle done pulse and a registered result.

Internally there is a single unsigned shift-add datapath. It retires `STEP` multiplier bits per cycle into a double-width accumulator. A result stage then picks the low half, the unsigned high half, or a signed high half. The signed forms come from the unsigned high half by subtracting the other operand once for each negative source. A word mode uses only the low half of each operand and runs half as many steps. Its low-half product is sign-extended to the full width.

Instruction decode, register access, hazards and exceptions belong to the surrounding pipe.

Top module: `imul_seq`

## Requirements
- R1: Code 0 (low) returns bits [63:0] of the product of src1 and src2; the value does not depend on operand signedness.
- R2: Code 1 (signed high) returns bits [127:64] of the product with both operands taken as two's complement signed.
- R3: Code 2 (mixed high) returns bits [127:64] of the product with src1 signed and src2 unsigned.
- R4: Code 3 (unsigned high) returns bits [127:64] of the product with both operands unsigned.
- R5: Code 4 (word) multiplies bits [31:0] of both operands and returns bits [31:0] of that product sign-extended from bit 31 to 64 bits; bits [63:32] of the operands have no effect.
- R6: Codes 5, 6 and 7 complete normally with a result of zero.
- R7: With the default STEP of 4, done is high 16 cycles after the clock edge that accepts a non-word start, and 8 cycles after the edge that accepts a word start.
- R8: busy is high from the edge after an accepted start until the edge at which done rises; a start while busy is high is ignored and neither alters the result nor causes an extra done.
- R9: done is high for exactly one cycle per accepted operation; result holds its value from one completion until the next.
- R10: A start presented in the cycle where done is high is accepted, and its own result follows with the normal latency.
- R11: After reset, result is zero and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while busy is low |
| op_i | input | 3 | Operation code (0 low, 1 signed high, 2 mixed high, 3 unsigned high, 4 word) |
| src1_i | input | 64 | First source operand |
| src2_i | input | 64 | Second source operand |
| result_o | output | 64 | Registered result of the last completed operation |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in flight |

## Verification
The completion of one operation and the acceptance of the next can share a cycle: busy drops at the same edge that raises done. A caller may therefore start again while done is still high. The bench provokes this by raising start in the exact cycle it first sees done. It then checks that done falls on the next cycle, that the old result stays visible, and that the second result arrives after its full latency. A separate case raises start in the middle of a running operation and checks that the result, the latency and the absence of a second done show the strobe was dropped.

// File: rtl/imul_pkg.sv
package imul_pkg;
  typedef enum logic [2:0] {
    OP_LO    = 3'd0,
    OP_HI_SS = 3'd1,
    OP_HI_SU = 3'd2,
    OP_HI_UU = 3'd3,
    OP_WORD  = 3'd4
  } imul_op_e;

  function automatic logic op_is_word(input logic [2:0] op);
    return op == OP_WORD;
  endfunction
endpackage

// File: rtl/imul_operand_prep.sv
module imul_operand_prep
  import imul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  input  logic [2:0]      op_i,
  output logic [XLEN-1:0] mcand_o,
  output logic [XLEN-1:0] mplier_o,
  output logic            word_o
);
  localparam int HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] low_half(input logic [XLEN-1:0] v);
    return {{(XLEN-HALF){1'b0}}, v[HALF-1:0]};
  endfunction

  always_comb begin
    word_o   = op_is_word(op_i);
    mcand_o  = word_o ? low_half(src1_i) : src1_i;
    mplier_o = word_o ? low_half(src2_i) : src2_i;
  end
endmodule

// File: rtl/imul_shift_add.sv
module imul_shift_add #(
  parameter int XLEN = 64,
  parameter int STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              run_i,
  input  logic              word_i,
  input  logic [XLEN-1:0]   mcand_i,
  input  logic [XLEN-1:0]   mplier_i,
  output logic [2*XLEN-1:0] prod_next_o,
  output logic              last_o
);
  localparam int PW        = 2 * XLEN;
  localparam int ITER_FULL = XLEN / STEP;
  localparam int ITER_WORD = XLEN / (2 * STEP);
  localparam int CW        = $clog2(ITER_FULL + 1);

  logic [PW-1:0]   acc_q;
  logic [PW-1:0]   mc_q;
  logic [XLEN-1:0] mp_q;
  logic [CW-1:0]   cnt_q;

  function automatic logic [PW-1:0] scale(input logic [PW-1:0] mc,
                                          input logic [STEP-1:0] digit);
    logic [PW-1:0] sum;
    sum = '0;
    for (int i = 0; i < STEP; i++) begin
      if (digit[i]) sum = sum + (mc << i);
    end
    return sum;
  endfunction

  assign prod_next_o = acc_q + scale(mc_q, mp_q[STEP-1:0]);
  assign last_o      = run_i && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      acc_q <= '0;
      mc_q  <= {{XLEN{1'b0}}, mcand_i};
      mp_q  <= mplier_i;
      cnt_q <= word_i ? CW'(ITER_WORD) : CW'(ITER_FULL);
    end else if (run_i) begin
      acc_q <= prod_next_o;
      mc_q  <= mc_q << STEP;
      mp_q  <= mp_q >> STEP;
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/imul_result_sel.sv
module imul_result_sel
  import imul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0] prod_i,
  input  logic [2:0]        op_i,
  input  logic [XLEN-1:0]   src1_i,
  input  logic [XLEN-1:0]   src2_i,
  output logic [XLEN-1:0]   res_o
);
  localparam int HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] fix_if_neg(input logic neg,
                                                 input logic [XLEN-1:0] other);
    return neg ? other : '0;
  endfunction

  logic [XLEN-1:0] hi_u, corr1, corr2;

  always_comb begin
    hi_u  = prod_i[2*XLEN-1:XLEN];
    corr1 = fix_if_neg(src1_i[XLEN-1], src2_i);
    corr2 = fix_if_neg(src2_i[XLEN-1], src1_i);
    unique case (op_i)
      OP_LO:    res_o = prod_i[XLEN-1:0];
      OP_HI_SS: res_o = hi_u - corr1 - corr2;
      OP_HI_SU: res_o = hi_u - corr1;
      OP_HI_UU: res_o = hi_u;
      OP_WORD:  res_o = {{(XLEN-HALF){prod_i[HALF-1]}}, prod_i[HALF-1:0]};
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/imul_seq.sv
module imul_seq
  import imul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  output logic [XLEN-1:0] result_o,
  output logic            done_o,
  output logic            busy_o
);
  logic              accept;
  logic              finish;
  logic [2:0]        op_q;
  logic [XLEN-1:0]   a_q, b_q;
  logic [XLEN-1:0]   mcand, mplier;
  logic              word;
  logic [2*XLEN-1:0] prod_next;
  logic [XLEN-1:0]   sel_res;

  assign accept = start_i & ~busy_o;

  imul_operand_prep #(.XLEN(XLEN)) u_prep (
    .src1_i  (src1_i),
    .src2_i  (src2_i),
    .op_i    (op_i),
    .mcand_o (mcand),
    .mplier_o(mplier),
    .word_o  (word)
  );

  imul_shift_add #(.XLEN(XLEN), .STEP(STEP)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .run_i      (busy_o),
    .word_i     (word),
    .mcand_i    (mcand),
    .mplier_i   (mplier),
    .prod_next_o(prod_next),
    .last_o     (finish)
  );

  imul_result_sel #(.XLEN(XLEN)) u_sel (
    .prod_i(prod_next),
    .op_i  (op_q),
    .src1_i(a_q),
    .src2_i(b_q),
    .res_o (sel_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
      op_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
    end else begin
      done_o <= finish;
      if (accept) begin
        busy_o <= 1'b1;
        op_q   <= op_i;
        a_q    <= src1_i;
        b_q    <= src2_i;
      end else if (finish) begin
        busy_o <= 1'b0;
      end
      if (finish) result_o <= sel_res;
    end
  end
endmodule

// File: rtl/imul_seq_chk.sv
module imul_seq_chk
  import imul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] result_o,
  input logic            done_o,
  input logic            busy_o,
  input logic            accept,
  input logic            finish,
  input logic [2:0]      op_q
);
  localparam int HALF      = XLEN / 2;
  localparam int ITER_FULL = XLEN / STEP;
  localparam int ITER_WORD = XLEN / (2 * STEP);
  localparam int LW        = $clog2(ITER_FULL + 2);

  logic [LW-1:0] lat_q;
  logic          pend_word_q;
  logic [2:0]    pend_op_q, done_op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q       <= '0;
      pend_word_q <= 1'b0;
      pend_op_q   <= '0;
      done_op_q   <= '0;
    end else begin
      if (accept) begin
        lat_q       <= '0;
        pend_word_q <= op_is_word(op_i);
        pend_op_q   <= op_i;
      end else if (busy_o) begin
        lat_q <= lat_q + LW'(1);
      end
      if (finish) done_op_q <= pend_op_q;
    end
  end

  // R7: last step falls on the expected cycle
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (lat_q == (pend_word_q ? LW'(ITER_WORD - 1) : LW'(ITER_FULL - 1))));

  // R8: accepted start makes the unit busy
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  // R8: a start while busy leaves the captured op untouched
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(op_q));

  // R8: busy falls only together with done
  p_busy_fall_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: result changes only with done
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  // R5: word result is sign-extended
  p_word_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_op_q == OP_WORD) |->
      (result_o[XLEN-1:HALF] == {(XLEN-HALF){result_o[HALF-1]}}));

  // R6: unknown codes give zero
  p_bad_op_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_op_q > 3'd4) |-> (result_o == '0));
endmodule

bind imul_seq imul_seq_chk #(.XLEN(XLEN), .STEP(STEP)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .op_i    (op_i),
  .result_o(result_o),
  .done_o  (done_o),
  .busy_o  (busy_o),
  .accept  (accept),
  .finish  (finish),
  .op_q    (op_q)
);

// File: tb/test_imul_seq.sv
module test_imul_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FULL_LAT   = 16;
  localparam int WORD_LAT   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] src1_i = '0;
  logic [63:0] src2_i = '0;
  logic [63:0] result_o;
  logic        done_o;
  logic        busy_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imul_seq i_imul_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .src1_i(src1_i), .src2_i(src2_i),
    .result_o(result_o), .done_o(done_o), .busy_o(busy_o)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [2:0] op);
    logic signed [127:0] ss, su;
    logic [127:0]        uu;
    logic signed [63:0]  w;
    ss = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
    su = $signed({{64{a[63]}}, a}) * $signed({64'b0, b});
    uu = {64'b0, a} * {64'b0, b};
    w  = $signed({{32{a[31]}}, a[31:0]}) * $signed({{32{b[31]}}, b[31:0]});
    case (op)
      3'd0:    return uu[63:0];
      3'd1:    return ss[127:64];
      3'd2:    return su[127:64];
      3'd3:    return uu[127:64];
      3'd4:    return {{32{w[31]}}, w[31:0]};
      default: return 64'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0:    return "R1";
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      3'd4:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge; start seen at the next posedge
  task automatic launch(input logic [63:0] a, input logic [63:0] b, input logic [2:0] op);
    start_i = 1'b1; op_i = op; src1_i = a; src2_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // returns negedges counted after launch until done (launch's own negedge counts as 1)
  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done_o && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [2:0] op);
    int cyc;
    int exp_cyc;
    launch(a, b, op);
    wait_done(cyc);
    exp_cyc = (op == 3'd4) ? WORD_LAT + 1 : FULL_LAT + 1;
    check(cyc == exp_cyc, "R7 latency", 64'(cyc), 64'(exp_cyc));
    check(result_o == model(a, b, op), tag_of(op), result_o, model(a, b, op));
  endtask

  logic [63:0] vals [8];

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [63:0] hold;
    vals[0] = 64'd0;
    vals[1] = 64'd1;
    vals[2] = '1;
    vals[3] = 64'h8000_0000_0000_0000;
    vals[4] = 64'h7fff_ffff_ffff_ffff;
    vals[5] = 64'd2;
    vals[6] = 64'h0000_0000_8000_0000;
    vals[7] = 64'h1234_5678_9abc_def1;

    repeat (3) @(negedge clk);
    // R11: reset state
    check(result_o == 64'd0, "R11 result", result_o, 64'd0);
    check({busy_o, done_o} == 2'b00, "R11 busy/done", 64'({busy_o, done_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1..R5 sweep over corner operands
    for (int op = 0; op < 5; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(vals[i], vals[j], 3'(op));

    // R5: upper operand bits have no effect in word mode
    run_op(64'hdead_beef_0000_0003, 64'h5555_aaaa_ffff_fffd, 3'd4);
    run_op(64'h0000_0000_7fff_ffff, 64'hffff_ffff_7fff_ffff, 3'd4);

    // R6: reserved codes
    for (int op = 5; op < 8; op++) begin
      run_op(vals[2], vals[7], 3'(op));
      run_op(vals[3], vals[3], 3'(op));
    end

    // R8: busy right after accept, mid-flight start ignored
    launch(vals[7], vals[2], 3'd3);
    check(busy_o == 1'b1, "R8 busy after start", 64'(busy_o), 64'd1);
    @(negedge clk);
    @(negedge clk);
    launch(vals[4], vals[5], 3'd0);
    cyc = 4;
    while (!done_o && cyc < 200) begin @(negedge clk); cyc++; end
    check(cyc == FULL_LAT + 1, "R8 latency unchanged", 64'(cyc), 64'(FULL_LAT + 1));
    check(result_o == model(vals[7], vals[2], 3'd3), "R8 ignored start",
          result_o, model(vals[7], vals[2], 3'd3));
    hold = result_o;
    // R9: pulse width and hold while inputs move
    src1_i = vals[3]; src2_i = vals[4]; op_i = 3'd1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(done_o == 1'b0, "R8 no extra done", 64'(done_o), 64'd0);
      check(busy_o == 1'b0, "R8 idle after ignored start", 64'(busy_o), 64'd0);
      check(result_o == hold, "R9 result hold", result_o, hold);
    end

    // R10: start in the done cycle
    launch(vals[3], vals[2], 3'd1);
    wait_done(cyc);
    hold = result_o;
    check(hold == model(vals[3], vals[2], 3'd1), "R2 before b2b", hold,
          model(vals[3], vals[2], 3'd1));
    launch(vals[7], vals[6], 3'd4);
    check(done_o == 1'b0, "R9 single pulse", 64'(done_o), 64'd0);
    check(result_o == hold, "R9 hold during next op", result_o, hold);
    check(busy_o == 1'b1, "R10 accepted in done cycle", 64'(busy_o), 64'd1);
    wait_done(cyc);
    check(cyc == WORD_LAT + 1, "R10 latency", 64'(cyc), 64'(WORD_LAT + 1));
    check(result_o == model(vals[7], vals[6], 3'd4), "R10 result", result_o,
          model(vals[7], vals[6], 3'd4));

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule